// File: doc/BRIEF.md
# Block-Granular DMA Request Generator

This block produces the DMA request line for a hash engine that has no input FIFO. Every word goes straight into the engine's message schedule, so the request cannot be paced by a fill level. Instead it asks for a whole 512-bit message block in one burst. The number of bus transfers in that burst depends on the configured transfer width.

Software first sets the width field and then pulses start. After that, the DMA controller runs until the request drops. The write port returns one acknowledge per accepted transfer. The engine lowers its ready flag while it digests the block. The request comes back once ready has been low for at least one clock edge and then returns high.

The transfer width is treated as quasi-static. It must be set before start is pulsed and must not change while a block is partly transferred.

Top module: `dreq_blk_gen`

## Requirements
- R1: After reset the transfer counter is zero and no block is complete, so `req_o` equals `ready_i`.
- R2: A block completes after 64, 32 or 16 counted acknowledges for `size_i` = 0 (8-bit), 1 (16-bit) or 2 (32-bit). The value 3 behaves like 2 (16 acknowledges).
- R3: `req_o` is low in every cycle in which `ready_i` is low.
- R4: The cycle after the final acknowledge of a block, `req_o` is low. It stays low while `ready_i` remains high and no start is given.
- R5: An acknowledge that arrives while `req_o` is low is not counted.
- R6: A start pulse clears the counter and the block-complete state. An acknowledge in the same cycle as start is not counted.
- R7: If `ready_i` drops partway through a block, the request pauses and the count is kept. When ready returns, only the remaining transfers are requested.
- R8: Once `ready_i` is sampled low at a clock edge after a completed block, the next block is requested from count zero when ready is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| size_i | input | 2 | Transfer width code: 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit |
| ready_i | input | 1 | Engine can accept block data |
| start_i | input | 1 | One-cycle pulse that starts a new hash |
| ack_i | input | 1 | One transfer accepted by the write port |
| req_o | output | 1 | DMA request |

## Verification
A wrong count or a wrong decode of the width code shows up at the port as a request that drops too early or too late. The error appears within one cycle of the block's final acknowledge, so the bench counts the acknowledges it can issue for every code. A stale block-complete flag or a lost count shows up as a request that fails to return after a ready toggle, or returns for the wrong number of transfers. It appears in the first cycle after ready returns. The bench sweeps all four width codes through complete blocks, ignored acknowledges, mid-block ready loss, and start colliding with an acknowledge.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  typedef enum logic [1:0] {
    XW_BYTE = 2'd0,
    XW_HALF = 2'd1,
    XW_WORD = 2'd2,
    XW_RSVD = 2'd3
  } xfer_width_e;

  // log2 of bytes per transfer; reserved code behaves as word
  function automatic int unsigned width_shift(xfer_width_e w);
    return (w == XW_RSVD) ? 2 : int'(w);
  endfunction
endpackage

// File: rtl/dreq_size_dec.sv
module dreq_size_dec #(
  parameter int unsigned BLOCK_BYTES = 64,
  parameter int unsigned CNT_W       = 6
) (
  input  logic [1:0]       size_i,
  output logic [CNT_W-1:0] last_idx_o
);
  import dreq_pkg::*;

  always_comb begin
    last_idx_o = CNT_W'((BLOCK_BYTES >> width_shift(xfer_width_e'(size_i))) - 1);
  end
endmodule

// File: rtl/dreq_xfer_cnt.sv
module dreq_xfer_cnt #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             pause_i,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] last_idx_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (pause_i) begin
      done_q <= 1'b0;  // engine busy: re-arm, keep partial count
    end else if (adv_i) begin
      if (cnt_q >= last_idx_i) begin
        cnt_q  <= '0;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign done_o = done_q;
endmodule

// File: rtl/dreq_blk_gen.sv
module dreq_blk_gen #(
  parameter int unsigned BLOCK_BITS = 512,
  localparam int unsigned BLOCK_BYTES = BLOCK_BITS / 8,
  localparam int unsigned CNT_W       = $clog2(BLOCK_BYTES)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] size_i,
  input  logic       ready_i,
  input  logic       start_i,
  input  logic       ack_i,
  output logic       req_o
);
  logic [CNT_W-1:0] last_idx;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             adv;

  dreq_size_dec #(
    .BLOCK_BYTES(BLOCK_BYTES),
    .CNT_W      (CNT_W)
  ) u_dec (
    .size_i    (size_i),
    .last_idx_o(last_idx)
  );

  assign adv = ack_i & req_o;

  dreq_xfer_cnt #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (start_i),
    .pause_i   (~ready_i),
    .adv_i     (adv),
    .last_idx_i(last_idx),
    .cnt_o     (cnt_q),
    .done_o    (done_q)
  );

  assign req_o = ready_i & ~done_q;
endmodule

// File: rtl/dreq_blk_gen_chk.sv
module dreq_blk_gen_chk #(
  parameter int unsigned CNT_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ready_i,
  input logic             start_i,
  input logic             ack_i,
  input logic             req_o,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] last_i,
  input logic             done_i
);
  // R3
  ready_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |-> !req_o);

  // R4
  blk_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && ack_i && !start_i && cnt_i >= last_i) |=> !req_o);

  // R4
  blk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && ready_i && !start_i) |=> !req_o);

  // R5
  ack_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_o && !start_i) |=> $stable(cnt_i));

  // R6
  start_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (cnt_i == '0 && !done_i));

  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= last_i);
endmodule

bind dreq_blk_gen dreq_blk_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .ready_i(ready_i),
  .start_i(start_i),
  .ack_i  (ack_i),
  .req_o  (req_o),
  .cnt_i  (cnt_q),
  .last_i (last_idx),
  .done_i (done_q)
);

// File: tb/dreq_blk_gen_tb.sv
`timescale 1ns/1ps
module dreq_blk_gen_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] size_i = 2'd2;
  logic       ready_i = 1'b0;
  logic       start_i = 1'b0;
  logic       ack_i = 1'b0;
  logic       req_o;

  int checks = 0;
  int errors = 0;
  bit done_run = 1'b0;

  always #10 clk_i = ~clk_i;

  dreq_blk_gen u_dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .size_i (size_i),
    .ready_i(ready_i),
    .start_i(start_i),
    .ack_i  (ack_i),
    .req_o  (req_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ack while request is high; returns number of counted transfers
  task automatic drain(output int n);
    n = 0;
    while (req_o && n < 200) begin
      ack_i = 1'b1;
      n++;
      @(negedge clk_i); #1;
    end
    ack_i = 1'b0;
  endtask

  task automatic ack_k(input int k);
    for (int i = 0; i < k; i++) begin
      ack_i = 1'b1;
      @(negedge clk_i); #1;
    end
    ack_i = 1'b0;
  endtask

  task automatic step();
    @(negedge clk_i); #1;
  endtask

  task automatic reopen();
    ready_i = 1'b0;
    step();
    ready_i = 1'b1;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done_run) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    int exp;
    step();
    // R1 reset state
    chk(req_o == 1'b0, "R1 ready low after reset", req_o, 0);
    rst_ni = 1'b1;
    step();
    ready_i = 1'b1;
    #1;
    chk(req_o == 1'b1, "R1 ready high after reset", req_o, 1);

    for (int s = 0; s < 4; s++) begin
      exp = 64 >> ((s == 3) ? 2 : s);
      size_i = 2'(s);
      start_i = 1'b1;
      step();
      start_i = 1'b0;
      #1;
      chk(req_o == 1'b1, "R6 request after start", req_o, 1);

      drain(n);
      chk(n == exp, $sformatf("R2 block length size %0d", s), n, exp);

      for (int i = 0; i < 3; i++) begin
        step();
        chk(req_o == 1'b0, "R4 low after block", req_o, 0);
      end

      ack_k(4);  // ignored: request is low
      chk(req_o == 1'b0, "R5 still low after stray acks", req_o, 0);

      ready_i = 1'b0;
      step();
      chk(req_o == 1'b0, "R3 low while not ready", req_o, 0);
      ready_i = 1'b1;
      #1;
      chk(req_o == 1'b1, "R8 request returns", req_o, 1);
      drain(n);
      chk(n == exp, $sformatf("R5 stray acks not counted size %0d", s), n, exp);

      // R7: partial block, ready drop with acks held
      reopen();
      ack_k(5);
      ready_i = 1'b0;
      ack_i = 1'b1;
      for (int i = 0; i < 3; i++) begin
        step();
        chk(req_o == 1'b0, "R3 paused mid-block", req_o, 0);
      end
      ack_i = 1'b0;
      ready_i = 1'b1;
      #1;
      chk(req_o == 1'b1, "R7 resume", req_o, 1);
      drain(n);
      chk(n == exp - 5, $sformatf("R7 remaining size %0d", s), n, exp - 5);

      // R6: start colliding with an ack mid-block
      reopen();
      ack_k(7);
      start_i = 1'b1;
      ack_i = 1'b1;
      step();
      start_i = 1'b0;
      ack_i = 1'b0;
      drain(n);
      chk(n == exp, $sformatf("R6 start clears count size %0d", s), n, exp);
      reopen();
    end

    done_run = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule